// File: doc/BRIEF.md
# Multi-Port Cell Transmit Master

This block is the cell-layer side master of a shared transmit bus that serves several PHY ports. It drives each port address in turn and reads the returned cell-available flag one clock later, keeping a bitmap of ports that can accept a cell. When a port is both ready and has a cell pending upstream, the master selects it by placing its address on the bus for one cycle. It then holds the active-low enable low while it streams a 53-byte cell, marking the first byte with a start-of-cell strobe.

Polling continues while a cell is in flight; the address lines are only taken from polling in a selection cycle. An upstream pause input can stop the stream at any byte position. A paused cell is resumed by driving the same port address again one clock before enable returns low. Ports with pending cells are served round-robin, starting after the port served last. The upstream side offers one pending flag per port and a byte source for the port that `port_o` names. The master takes a byte on every clock edge at which `byte_rd_o` is high.

Top module: `utx_master`

## Requirements
- R1: While reset is active, and in the first cycle after it, the bus address is the null code 0x1F, enable is high and start-of-cell is low.
- R2: Only port addresses 0..NUM_PORTS-1 or 0x1F appear on the bus. The flag returned one cycle after a poll address sets that port's ready bit. A cell never starts to a port whose last poll answer was low, so a PHY with no free cell buffer is never overrun.
- R3: In the cycle before enable falls, the bus address equals the port being served. That cycle carries no poll.
- R4: A cell is 53 bytes. Start-of-cell is high with the first byte only, and enable is high in the cycle after the 53rd byte.
- R5: While enable is low, the address lines keep carrying poll addresses.
- R6: If pause_i is high at an edge where a byte would be taken, no byte is taken and enable is high in the next cycle. A pause raised before the first byte holds the whole cell back. A pause on the last byte is ignored.
- R7: After a pause, the paused port's address is driven exactly one cycle before enable goes low again.
- R8: No other port is selected until the current cell is complete. Every byte reaches the bus once and in order, across any pattern of pauses.
- R9: Among ports that are ready and pending, the next cell goes to the first such port after the one served last, in ascending order with wrap. After reset the search starts at port 0.
- R10: When no port has a cell pending, the address lines carry 0x1F.
- R11: byte_rd_o is high for exactly the edges at which data_i is taken. That byte appears on utx_data_o, with enable low, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_PORTS | Per-port cell pending; held until the cell's last byte is taken |
| data_i | input | DATA_W | Next byte of the cell for the port on port_o |
| pause_i | input | 1 | Pause request, stops byte transfer |
| byte_rd_o | output | 1 | data_i is taken at this edge |
| port_o | output | PORT_W | Port currently or last served |
| utx_addr_o | output | ADDR_W | Bus address: poll, select or null |
| utx_clav_i | input | 1 | Cell-available answer from the PHY |
| utx_enb_no | output | 1 | Active-low transmit enable |
| utx_data_o | output | DATA_W | Bus data byte |
| utx_soc_o | output | 1 | Start-of-cell, first byte only |

## Verification
The bench models PHYs with finite cell buffers and starves one port. A master that trusted a stale ready bit, or a poll answer taken before its own cell started, would overrun that buffer. Random and directed pauses, placed at the first byte and in mid-cell, expose resumes without the one-cycle reselection and any byte dropped or repeated across a pause. Because the scoreboard is kept per port, a port switch in mid-cell shows up as a mismatch. A fixed service order with every port pending catches an arbiter that restarts at port 0 or repeats the last winner.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_XFER,
    ST_HOLD,
    ST_RESEL
  } utx_state_e;
endpackage

// File: rtl/utx_poll_map.sv
module utx_poll_map #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 poll_en_i,
  input  logic                 clav_i,
  input  logic                 busy_i,
  input  logic [PORT_W-1:0]    cur_i,
  input  logic                 fire_i,
  input  logic [PORT_W-1:0]    pick_i,
  output logic [PORT_W-1:0]    poll_idx_o,
  output logic [NUM_PORTS-1:0] ready_o
);
  localparam logic [PORT_W-1:0] LAST_IDX = PORT_W'(NUM_PORTS - 1);

  logic [PORT_W-1:0]    idx_q, t1_p_q, t2_p_q;
  logic                 t1_v_q, t2_v_q;
  logic [NUM_PORTS-1:0] ready_q, ready_d;

  // answer for the address of two edges ago arrives now; drop answers for a busy port
  always_comb begin
    ready_d = ready_q;
    if (t2_v_q && !(busy_i && t2_p_q == cur_i) && !(fire_i && t2_p_q == pick_i))
      ready_d[t2_p_q] = clav_i;
    if (fire_i) ready_d[pick_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      t1_p_q  <= '0;
      t2_p_q  <= '0;
      t1_v_q  <= 1'b0;
      t2_v_q  <= 1'b0;
      ready_q <= '0;
    end else begin
      if (poll_en_i) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      t1_v_q  <= poll_en_i;
      t1_p_q  <= idx_q;
      t2_v_q  <= t1_v_q;
      t2_p_q  <= t1_p_q;
      ready_q <= ready_d;
    end
  end

  assign poll_idx_o = idx_q;
  assign ready_o    = ready_q;
endmodule

// File: rtl/utx_rr_pick.sv
module utx_rr_pick #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 2
) (
  input  logic [NUM_PORTS-1:0] elig_i,
  input  logic [PORT_W-1:0]    last_i,
  output logic [PORT_W-1:0]    pick_o,
  output logic                 any_o
);
  function automatic logic [PORT_W-1:0] rr_first(logic [NUM_PORTS-1:0] elig,
                                                 logic [PORT_W-1:0] last);
    logic [PORT_W:0]   s;
    logic [PORT_W-1:0] win;
    win = last;
    // walk from farthest to nearest so the nearest eligible port wins
    for (int k = NUM_PORTS; k >= 1; k--) begin
      s = {1'b0, last} + (PORT_W+1)'(k);
      if (s >= (PORT_W+1)'(NUM_PORTS)) s = s - (PORT_W+1)'(NUM_PORTS);
      if (elig[s[PORT_W-1:0]]) win = s[PORT_W-1:0];
    end
    return win;
  endfunction

  assign pick_o = rr_first(elig_i, last_i);
  assign any_o  = |elig_i;
endmodule

// File: rtl/utx_master.sv
module utx_master
  import utx_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53,
  parameter logic [ADDR_W-1:0] NULL_ADDR = '1,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] pend_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 pause_i,
  output logic                 byte_rd_o,
  output logic [PORT_W-1:0]    port_o,
  output logic [ADDR_W-1:0]    utx_addr_o,
  input  logic                 utx_clav_i,
  output logic                 utx_enb_no,
  output logic [DATA_W-1:0]    utx_data_o,
  output logic                 utx_soc_o
);
  localparam int unsigned CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CELL_BYTES);

  utx_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q;
  logic [PORT_W-1:0]   cur_q, last_q, pick, poll_idx, port_next;
  logic [NUM_PORTS-1:0] ready;
  logic                any, fire, take, sel_next, poll_en, busy;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                enb_nq, soc_q;
  logic [DATA_W-1:0]   data_q;

  utx_rr_pick #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_pick (
    .elig_i (ready & pend_i),
    .last_i (last_q),
    .pick_o (pick),
    .any_o  (any)
  );

  utx_poll_map #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .poll_en_i  (poll_en),
    .clav_i     (utx_clav_i),
    .busy_i     (busy),
    .cur_i      (cur_q),
    .fire_i     (fire),
    .pick_i     (pick),
    .poll_idx_o (poll_idx),
    .ready_o    (ready)
  );

  assign busy = (state_q != ST_IDLE);
  assign fire = (state_q == ST_IDLE) && any;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fire) state_d = ST_SEL;
      ST_SEL:   state_d = pause_i ? ST_HOLD : ST_XFER;
      ST_XFER:  if (cnt_q == FULL_CNT) state_d = ST_IDLE;
                else if (pause_i)      state_d = ST_HOLD;
      ST_HOLD:  if (!pause_i) state_d = ST_RESEL;
      ST_RESEL: state_d = pause_i ? ST_HOLD : ST_XFER;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign take = !pause_i && ((state_q == ST_SEL) || (state_q == ST_RESEL) ||
                             ((state_q == ST_XFER) && (cnt_q != FULL_CNT)));

  // selection cycles own the address lines; otherwise poll while work is pending
  assign sel_next  = (state_d == ST_SEL) || (state_d == ST_RESEL);
  assign port_next = fire ? pick : cur_q;
  assign poll_en   = !sel_next && (|pend_i);

  always_comb begin
    if (sel_next)     addr_d = ADDR_W'(port_next);
    else if (poll_en) addr_d = ADDR_W'(poll_idx);
    else              addr_d = NULL_ADDR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      last_q  <= PORT_W'(NUM_PORTS - 1);
      addr_q  <= NULL_ADDR;
      enb_nq  <= 1'b1;
      soc_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      enb_nq  <= !take;
      soc_q   <= take && (cnt_q == '0);
      if (fire) begin
        cur_q  <= pick;
        last_q <= pick;
        cnt_q  <= '0;
      end else if (take) begin
        cnt_q  <= cnt_q + 1'b1;
      end
      if (take) data_q <= data_i;
    end
  end

  assign byte_rd_o  = take;
  assign port_o     = cur_q;
  assign utx_addr_o = addr_q;
  assign utx_enb_no = enb_nq;
  assign utx_data_o = data_q;
  assign utx_soc_o  = soc_q;
endmodule

// File: rtl/utx_master_chk.sv
module utx_master_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PORT_W    = 2,
  parameter logic [ADDR_W-1:0] NULL_ADDR = '1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PORTS-1:0] pend_i,
  input logic [DATA_W-1:0]    data_i,
  input logic                 byte_rd_o,
  input logic [PORT_W-1:0]    port_o,
  input logic [ADDR_W-1:0]    utx_addr_o,
  input logic                 utx_enb_no,
  input logic [DATA_W-1:0]    utx_data_o,
  input logic                 utx_soc_o
);
  p_addr_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (utx_addr_o < ADDR_W'(NUM_PORTS)) || (utx_addr_o == NULL_ADDR));

  p_sel_before_enb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(utx_enb_no) |-> ($past(utx_addr_o) == ADDR_W'($past(port_o))));

  p_soc_with_enb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utx_soc_o |-> !utx_enb_no);

  p_port_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !utx_enb_no |-> $stable(port_o));

  p_null_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (utx_addr_o == NULL_ADDR));

  p_rd_to_bus_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_rd_o |=> (!utx_enb_no && (utx_data_o == $past(data_i))));
endmodule

bind utx_master utx_master_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PORT_W    (PORT_W),
  .NULL_ADDR (NULL_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pend_i     (pend_i),
  .data_i     (data_i),
  .byte_rd_o  (byte_rd_o),
  .port_o     (port_o),
  .utx_addr_o (utx_addr_o),
  .utx_enb_no (utx_enb_no),
  .utx_data_o (utx_data_o),
  .utx_soc_o  (utx_soc_o)
);

// File: tb/utx_master_tb_top.sv
module utx_master_tb_top;
  localparam int NP = 4;
  localparam int CB = 53;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pend_i;
  logic [7:0]    data_i;
  logic          pause_i = 1'b0;
  logic          byte_rd_o;
  logic [1:0]    port_o;
  logic [4:0]    utx_addr_o;
  logic          utx_clav_i = 1'b0;
  logic          utx_enb_no;
  logic [7:0]    utx_data_o;
  logic          utx_soc_o;

  utx_master dut_i (
    .clk_i, .rst_ni, .pend_i, .data_i, .pause_i, .byte_rd_o, .port_o,
    .utx_addr_o, .utx_clav_i, .utx_enb_no, .utx_data_o, .utx_soc_o
  );

  always #10 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  int room [NP];
  int sent [NP];
  int queued [NP];
  logic [7:0] exp_q [NP][$];
  int order_q [$];
  logic [4:0] prev_addr = 5'h1F;
  logic prev_enb = 1'b1;
  int pos = 0, cell_port = 0;
  int polls_in_xfer = 0, resumes = 0, rd_total = 0, bus_total = 0;
  bit rd_cap = 0;
  int rd_port = 0;
  bit pause_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] gen(int p, int k);
    return 8'((p * 61 + k * 7 + (k >> 3)) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always_comb begin
    for (int p = 0; p < NP; p++) pend_i[p] = (sent[p] < queued[p]);
    data_i = gen(int'(port_o), sent[port_o]);
  end

  // upstream take capture, after pause_i has settled
  always @(negedge clk_i) begin
    #5;
    rd_cap  = byte_rd_o;
    rd_port = int'(port_o);
  end

  // upstream source, PHY model and scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rd_cap) begin
        sent[rd_port]++;
        rd_total++;
        rd_cap = 0;
      end
      if (!utx_enb_no) begin
        bus_total++;
        if (prev_enb) begin
          chk(prev_addr < 5'(NP), "R3 select addr", int'(prev_addr), cell_port);
          if (pos == 0) cell_port = int'(prev_addr);
          else begin
            resumes++;
            chk(int'(prev_addr) == cell_port, "R7 reselect", int'(prev_addr), cell_port);
          end
        end else if (pos == 0) begin
          chk(1'b0, "R4 enable gap after cell", 0, 1);
        end
        chk(utx_soc_o == (pos == 0), "R4 soc", int'(utx_soc_o), int'(pos == 0));
        if (pos == 0 && cell_port < NP) begin
          chk(room[cell_port] > 0, "R2 no overrun", room[cell_port], 1);
          room[cell_port]--;
          order_q.push_back(cell_port);
        end
        if (cell_port < NP && exp_q[cell_port].size() > 0) begin
          logic [7:0] e;
          e = exp_q[cell_port].pop_front();
          chk(utx_data_o == e, "R8 byte", int'(utx_data_o), int'(e));
        end else begin
          chk(1'b0, "R8 unexpected byte", int'(utx_data_o), -1);
        end
        if (utx_addr_o < 5'(NP)) polls_in_xfer++;
        pos = (pos == CB - 1) ? 0 : pos + 1;
      end
      utx_clav_i = (prev_addr < 5'(NP)) ? (room[prev_addr[1:0]] > 0) : 1'b0;
      prev_addr  = utx_addr_o;
      prev_enb   = utx_enb_no;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pause_rand) pause_i = (lfsr[1:0] == 2'b00);
    end
  end

  task automatic tick();
    @(negedge clk_i);
    #2;
  endtask

  task automatic queue_cells(int p, int n);
    for (int c = 0; c < n * CB; c++) exp_q[p].push_back(gen(p, queued[p] + c));
    queued[p] += n * CB;
  endtask

  task automatic wait_drain(string req);
    bit done = 0;
    for (int i = 0; i < 20000 && !done; i++) begin
      tick();
      done = 1;
      for (int p = 0; p < NP; p++) if (sent[p] != queued[p]) done = 0;
      if (pos != 0 || !utx_enb_no) done = 0;
    end
    chk(done, req, 0, 1);
  endtask

  initial begin
    int exp_ord [8] = '{2, 3, 0, 1, 2, 3, 0, 1};
    int base3;
    for (int p = 0; p < NP; p++) begin room[p] = 100; sent[p] = 0; queued[p] = 0; end
    repeat (3) tick();
    chk(utx_addr_o == 5'h1F, "R1 addr in reset", int'(utx_addr_o), 31);
    chk(utx_enb_no == 1'b1, "R1 enb in reset", int'(utx_enb_no), 1);
    chk(utx_soc_o == 1'b0, "R1 soc in reset", int'(utx_soc_o), 0);
    rst_ni = 1'b1;
    tick();
    chk(utx_addr_o == 5'h1F, "R1 addr after reset", int'(utx_addr_o), 31);
    chk(utx_enb_no == 1'b1, "R1 enb after reset", int'(utx_enb_no), 1);

    // single cell
    queue_cells(1, 1);
    wait_drain("R4 single cell done");
    chk(order_q.size() == 1 && order_q[0] == 1, "R9 first port", order_q.size() > 0 ? order_q[0] : -1, 1);

    // every port pending: round-robin order continues after port 1
    order_q.delete();
    for (int p = 0; p < NP; p++) queue_cells(p, 2);
    wait_drain("R8 all ports drained");
    chk(order_q.size() == 8, "R9 cell count", order_q.size(), 8);
    for (int i = 0; i < 8 && i < order_q.size(); i++)
      chk(order_q[i] == exp_ord[i], "R9 order", order_q[i], exp_ord[i]);
    chk(polls_in_xfer > 0, "R5 poll during cell", polls_in_xfer, 1);

    // starve port 3 to one buffer
    room[3] = 1;
    base3 = sent[3];
    queue_cells(3, 3);
    queue_cells(0, 1);
    repeat (600) tick();
    chk(sent[3] - base3 == CB, "R2 full port held", sent[3] - base3, CB);
    chk(sent[0] == queued[0], "R2 other port served", sent[0], queued[0]);
    room[3] = 5;
    wait_drain("R2 starved port drained");

    // random pauses
    pause_rand = 1;
    for (int p = 0; p < NP; p++) queue_cells(p, 3);
    wait_drain("R8 drained under pauses");
    pause_rand = 0;
    tick();
    pause_i = 1'b0;
    chk(resumes > 0, "R7 resumes seen", resumes, 1);

    // pause before the first byte
    pause_i = 1'b1;
    base3 = sent[2];
    queue_cells(2, 1);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(utx_enb_no == 1'b1, "R6 held before first byte", int'(utx_enb_no), 1);
    end
    chk(sent[2] == base3, "R6 no byte taken", sent[2], base3);
    pause_i = 1'b0;

    // pause in mid-cell
    for (int i = 0; i < 200 && pos != 20; i++) tick();
    pause_i = 1'b1;
    tick();
    chk(utx_enb_no == 1'b1, "R6 enb high on pause", int'(utx_enb_no), 1);
    tick();
    chk(utx_enb_no == 1'b1, "R6 enb stays high", int'(utx_enb_no), 1);
    chk(pos == 21 || pos == 20, "R6 position kept", pos, 21);
    pause_i = 1'b0;
    wait_drain("R7 paused cell completed");

    // idle bus
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(utx_addr_o == 5'h1F, "R10 null when idle", int'(utx_addr_o), 31);
    end
    for (int p = 0; p < NP; p++)
      chk(exp_q[p].size() == 0, "R8 scoreboard empty", exp_q[p].size(), 0);
    chk(rd_total == bus_total, "R11 take count", rd_total, bus_total);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule